// File: doc/BRIEF.md
# Dual-Integrator Integrate/Measure Sequencer

This block is the control state machine for a current-input converter front end. Each channel there has two integrator sides, A and B, which take turns. One side collects charge while the other is measured, reset and auto-zeroed (an m/r/az cycle). The block reads the level of an external conversion-control input `conv_i` through a synchronizer. It runs its own m/r/az busy timer and drives the enables for the integrators and the measurement path.

There are eight states. States 3 to 6 form continuous mode, in which one side is always integrating. States 1, 2, 7 and 8 form non-continuous mode. The machine falls into that mode when the control level flips while an m/r/az cycle is still running. In it the inputs are grounded, the outstanding measurements finish, and the next side is prepared before integration resumes. Integration always alternates between the two sides. Inverting the control input gives the mirrored state sequence.

Top module: `intmeas_seq`

## Requirements
- R1: While `rst_i` is high, `state_o` becomes 1 if the synchronized control level is high and 8 if it is low. `state_o` carries the state number 1..8 as an unsigned 4-bit value.
- R2: The continuous states drive the outputs as follows. In state 3, only `int_a_o` is high. In state 4, `int_b_o` is high while side A's m/r/az runs. In state 5, `int_a_o` is high while side B's m/r/az runs. In state 6, only `int_b_o` is high. `cont_o` is high exactly in states 3 to 6.
- R3: With the m/r/az timer idle, a low control level moves 3→4 and 5→4, and a high level moves 4→5 and 6→5. A steady level keeps a continuous state unchanged.
- R4: A high control level in state 4 while `mbsy_o` is high moves to state 1. A low level in state 5 while `mbsy_o` is high moves to state 8.
- R5: State 1 first lets side A's m/r/az end. If it was entered from state 4, it then runs side B's m/r/az. State 8 does the same with the sides swapped. The control level has no effect while in state 1 or 8.
- R6: State 1 goes to state 2, and state 8 to state 7, only once the timer is idle with nothing pending. A prep state lasts at least PREP_CYCLES clocks. It then advances to state 3 when the level is high (from state 2) or to state 6 when it is low (from state 7), and waits otherwise.
- R7: `gnd_o` is high exactly in states 1, 2, 7 and 8. Neither integrate enable is high in those states.
- R8: `meas_a_o` / `meas_b_o` is a single-cycle pulse marking the start of that side's m/r/az. `mbsy_o` rises in the same cycle and stays high for exactly MRAZ_CYCLES cycles.
- R9: `prep_o` is a single-cycle pulse in the first cycle of state 2 or state 7.
- R10: Each new integration uses the side opposite to the previous one, whatever the control pattern.
- R11: Driving the inverted control pattern from reset maps each state s onto 9−s and swaps sides A and B.
- R12: A change of `conv_i` reaches the state on the third rising clock edge after it, because of the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Asynchronous conversion-control level |
| int_a_o | output | 1 | Side A integrate enable |
| int_b_o | output | 1 | Side B integrate enable |
| meas_a_o | output | 1 | Side A m/r/az start pulse |
| meas_b_o | output | 1 | Side B m/r/az start pulse |
| prep_o | output | 1 | Prep-state entry strobe |
| gnd_o | output | 1 | Ground the inputs (non-continuous mode) |
| cont_o | output | 1 | Continuous-mode flag |
| mbsy_o | output | 1 | m/r/az timer busy |
| state_o | output | 4 | Current state number 1..8 |

## Verification
The bench builds the block with MRAZ_CYCLES = 6, PREP_CYCLES = 3 and SYNC_STAGES = 2. A six-cycle busy window lets a control flip land inside a running m/r/az within a handful of clocks, so both non-continuous entries, the pending second measurement and the prep wait are reached quickly. The same control script then runs inverted from a fresh reset, and the mirrored state numbers are checked against it.

// File: rtl/intmeas_pkg.sv
package intmeas_pkg;

    typedef enum logic [3:0] {
        ST_NC_A   = 4'd1,
        ST_PREP_A = 4'd2,
        ST_INT_A  = 4'd3,
        ST_IB_MA  = 4'd4,
        ST_IA_MB  = 4'd5,
        ST_INT_B  = 4'd6,
        ST_PREP_B = 4'd7,
        ST_NC_B   = 4'd8
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       pend;
        logic       meas_a;
        logic       meas_b;
        logic       prep;
    } seq_reg_t;

endpackage

// File: rtl/intmeas_sync.sv
module intmeas_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk_i) ff_q[0] <= d_i;
        end else begin : g_next
            always_ff @(posedge clk_i) ff_q[i] <= ff_q[i-1];
        end
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/intmeas_timer.sv
module intmeas_timer #(
    parameter int LOAD  = 8,
    parameter int WIDTH = $clog2(LOAD + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam logic [WIDTH-1:0] LOAD_V = WIDTH'(LOAD);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start_i)
            cnt_d = LOAD_V;
        else if (cnt_q != '0)
            cnt_d = cnt_q - WIDTH'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R8: a start loads the full count
    a_r8_load: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> cnt_q == LOAD_V);

    // R8: without a start the count falls by one each clock
    a_r8_countdown: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o && !start_i |=> cnt_q == $past(cnt_q) - WIDTH'(1));
endmodule

// File: rtl/intmeas_decode.sv
module intmeas_decode
    import intmeas_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  seq_state_e st_i,
    output logic       int_a_o,
    output logic       int_b_o,
    output logic       gnd_o,
    output logic       cont_o
);
    always_comb begin
        int_a_o = 1'b0;
        int_b_o = 1'b0;
        cont_o  = 1'b1;
        unique case (st_i)
            ST_INT_A, ST_IA_MB: int_a_o = 1'b1;
            ST_INT_B, ST_IB_MA: int_b_o = 1'b1;
            default:            cont_o  = 1'b0;
        endcase
        gnd_o = !cont_o;
    end

    // R2: never both sides integrating
    a_r2_one_side: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({int_a_o, int_b_o}));

    // R7: a grounded input never has an integrator enabled
    a_r7_gnd_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        gnd_o |-> !(int_a_o || int_b_o));
endmodule

// File: rtl/intmeas_seq.sv
module intmeas_seq
    import intmeas_pkg::*;
#(
    parameter int MRAZ_CYCLES = 64,
    parameter int PREP_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       conv_i,
    output logic       int_a_o,
    output logic       int_b_o,
    output logic       meas_a_o,
    output logic       meas_b_o,
    output logic       prep_o,
    output logic       gnd_o,
    output logic       cont_o,
    output logic       mbsy_o,
    output logic [3:0] state_o
);
    localparam int MRAZ_W = $clog2(MRAZ_CYCLES + 1);
    localparam int PREP_W = $clog2(PREP_CYCLES + 1);

    logic     conv_s;
    logic     mbsy, prep_busy;
    logic     mraz_go, prep_go;
    seq_reg_t cur_d, cur_q;

    intmeas_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .d_i   (conv_i),
        .q_o   (conv_s)
    );

    intmeas_timer #(.LOAD(MRAZ_CYCLES), .WIDTH(MRAZ_W)) u_mraz (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (mraz_go),
        .busy_o  (mbsy)
    );

    intmeas_timer #(.LOAD(PREP_CYCLES), .WIDTH(PREP_W)) u_prep (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (prep_go),
        .busy_o  (prep_busy)
    );

    always_comb begin
        cur_d        = cur_q;
        cur_d.meas_a = 1'b0;
        cur_d.meas_b = 1'b0;
        cur_d.prep   = 1'b0;
        mraz_go      = 1'b0;
        prep_go      = 1'b0;
        unique case (cur_q.st)
            ST_INT_A: if (!conv_s) begin
                cur_d.st = ST_IB_MA; cur_d.meas_a = 1'b1; mraz_go = 1'b1;
            end
            ST_IB_MA: if (conv_s) begin
                if (mbsy) begin
                    cur_d.st = ST_NC_A; cur_d.pend = 1'b1;
                end else begin
                    cur_d.st = ST_IA_MB; cur_d.meas_b = 1'b1; mraz_go = 1'b1;
                end
            end
            ST_IA_MB: if (!conv_s) begin
                if (mbsy) begin
                    cur_d.st = ST_NC_B; cur_d.pend = 1'b1;
                end else begin
                    cur_d.st = ST_IB_MA; cur_d.meas_a = 1'b1; mraz_go = 1'b1;
                end
            end
            ST_INT_B: if (conv_s) begin
                cur_d.st = ST_IA_MB; cur_d.meas_b = 1'b1; mraz_go = 1'b1;
            end
            ST_NC_A: if (!mbsy) begin
                if (cur_q.pend) begin
                    cur_d.pend = 1'b0; cur_d.meas_b = 1'b1; mraz_go = 1'b1;
                end else begin
                    cur_d.st = ST_PREP_A; cur_d.prep = 1'b1; prep_go = 1'b1;
                end
            end
            ST_NC_B: if (!mbsy) begin
                if (cur_q.pend) begin
                    cur_d.pend = 1'b0; cur_d.meas_a = 1'b1; mraz_go = 1'b1;
                end else begin
                    cur_d.st = ST_PREP_B; cur_d.prep = 1'b1; prep_go = 1'b1;
                end
            end
            ST_PREP_A: if (!prep_busy && conv_s)  cur_d.st = ST_INT_A;
            ST_PREP_B: if (!prep_busy && !conv_s) cur_d.st = ST_INT_B;
            default:   cur_d.st = conv_s ? ST_NC_A : ST_NC_B;
        endcase
        if (rst_i) begin
            cur_d = '{st: (conv_s ? ST_NC_A : ST_NC_B), pend: 1'b0,
                      meas_a: 1'b0, meas_b: 1'b0, prep: 1'b0};
            mraz_go = 1'b0;
            prep_go = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= cur_d;
    end

    intmeas_decode u_dec (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .st_i    (cur_q.st),
        .int_a_o (int_a_o),
        .int_b_o (int_b_o),
        .gnd_o   (gnd_o),
        .cont_o  (cont_o)
    );

    assign meas_a_o = cur_q.meas_a;
    assign meas_b_o = cur_q.meas_b;
    assign prep_o   = cur_q.prep;
    assign mbsy_o   = mbsy;
    assign state_o  = cur_q.st;

    // R3: a steady high level keeps side A integrating in state 3
    a_r3_hold_a: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_q.st == ST_INT_A && conv_s |=> cur_q.st == ST_INT_A);

    // R4: a flip during a running m/r/az drops into non-continuous mode
    a_r4_drop_a: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_q.st == ST_IB_MA && conv_s && mbsy |=> cur_q.st == ST_NC_A);
    a_r4_drop_b: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_q.st == ST_IA_MB && !conv_s && mbsy |=> cur_q.st == ST_NC_B);

    // R6: prep entered only after the busy timer went idle
    a_r6_prep_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_q.st == ST_PREP_A && $past(cur_q.st) == ST_NC_A |-> !$past(mbsy));

    // R8: a measurement start coincides with the busy flag
    a_r8_meas_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        (meas_a_o || meas_b_o) |-> mbsy_o);

    // R9: prep strobe lasts one cycle
    a_r9_prep_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        prep_o |=> !prep_o);
endmodule

// File: tb/sim_intmeas_seq.sv
module sim_intmeas_seq;
    localparam int MRAZ = 6;
    localparam int PREP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv = 1'b1;
    logic int_a, int_b, meas_a, meas_b, prep, gnd, cont, mbsy;
    logic [3:0] state;

    always #10 clk = ~clk;

    intmeas_seq #(.MRAZ_CYCLES(MRAZ), .PREP_CYCLES(PREP), .SYNC_STAGES(2)) u0 (
        .clk_i (clk), .rst_i (rst), .conv_i (conv),
        .int_a_o (int_a), .int_b_o (int_b), .meas_a_o (meas_a), .meas_b_o (meas_b),
        .prep_o (prep), .gnd_o (gnd), .cont_o (cont), .mbsy_o (mbsy), .state_o (state)
    );

    typedef struct {
        int    st;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   inv    = 1'b0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: apply a level for some cycles, then expect a state
    task automatic hold(input logic lvl, input int cyc, input int st, input string req);
        exp_t e;
        @(negedge clk);
        conv = inv ? !lvl : lvl;
        repeat (cyc) @(posedge clk);
        e.st  = inv ? 9 - st : st;
        e.req = inv ? {req, " R11"} : req;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input logic lvl);
        exp_t e;
        @(negedge clk);
        conv = inv ? !lvl : lvl;
        rst  = 1'b1;
        repeat (6) @(posedge clk);
        e.st  = inv ? 8 : 1;
        e.req = inv ? "R1 R11" : "R1";
        exp_q.push_back(e);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: pop expected items and compare state and decoded outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            int   code_a, code_e;
            e = exp_q.pop_front();
            code_e = (e.st == 3 || e.st == 5 ? 1 : 0) + (e.st == 4 || e.st == 6 ? 2 : 0)
                   + (e.st >= 3 && e.st <= 6 ? 4 : 8);
            code_a = int'(int_a) + 2 * int'(int_b) + 4 * int'(cont) + 8 * int'(gnd);
            chk(int'(state) == e.st, {e.req, " state"}, int'(state), e.st);
            chk(code_a == code_e, {e.req, " R2 R7 outputs"}, code_a, code_e);
        end
    end

    // R8: measurement pulse width and busy window length
    int  busy_run = 0;
    bit  tracking = 1'b0;
    logic meas_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            tracking  = 1'b0;
            meas_prev = 1'b0;
        end else begin
            if (tracking && !mbsy) begin
                chk(busy_run == MRAZ, "R8 busy length", busy_run, MRAZ);
                tracking = 1'b0;
            end
            if (meas_a || meas_b) begin
                chk(!meas_prev, "R8 single-cycle start", 2, 1);
                tracking = 1'b1;
                busy_run = 0;
            end
            if (tracking && mbsy) busy_run++;
            meas_prev = meas_a || meas_b;
        end
    end

    // R9 and R10: prep strobe placement, side alternation
    int   last_side = 0;
    int   prev_side = 0;
    logic prep_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            last_side = 0;
            prev_side = 0;
            prep_prev = 1'b0;
        end else begin
            int now_side;
            now_side = int_a ? 1 : (int_b ? 2 : 0);
            if (now_side != 0 && now_side != prev_side) begin
                if (last_side != 0)
                    chk(now_side != last_side, "R10 alternation", now_side, 3 - last_side);
                last_side = now_side;
            end
            prev_side = now_side;
            if (prep) begin
                chk(!prep_prev && (state == 4'd2 || state == 4'd7), "R9 prep strobe",
                    int'(state), 2);
            end
            prep_prev = prep;
        end
    end

    task automatic script();
        do_reset(1'b1);
        hold(1'b1, 2, 2, "R6 prep entry");
        hold(1'b1, 20, 3, "R6 prep exit");
        hold(1'b0, 20, 4, "R3 3to4");
        hold(1'b1, 20, 5, "R3 4to5");
        hold(1'b0, 20, 4, "R3 5to4");
        hold(1'b1, 20, 5, "R3 4to5");
        hold(1'b0, 4, 4, "R2 meas A");
        hold(1'b1, 3, 1, "R4 4to1");
        hold(1'b1, 30, 3, "R5 finish both");
        hold(1'b0, 20, 4, "R3 3to4");
        hold(1'b1, 4, 5, "R2 meas B");
        hold(1'b0, 3, 8, "R4 5to8");
        hold(1'b0, 30, 6, "R5 finish both");
        hold(1'b1, 20, 5, "R3 6to5");
        hold(1'b0, 4, 4, "R2 meas A");
        hold(1'b1, 3, 1, "R4 4to1");
        hold(1'b0, 30, 2, "R6 prep wait");
        hold(1'b1, 5, 3, "R6 prep release");
        hold(1'b0, 2, 3, "R12 not yet");
        hold(1'b0, 1, 4, "R12 third edge");
        hold(1'b0, 20, 4, "R3 steady");
    endtask

    initial begin
        inv = 1'b0;
        script();
        inv = 1'b1;
        script();
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule